// File: doc/BRIEF.md
# Ones-Catching Master-Slave JK Flip-Flop

This block models a pulse-triggered master-slave JK flip-flop inside a fast synchronous design. A slow flip-flop clock `cp` and the `j` and `k` inputs are sampled on every edge of the system clock `clk`. While `cp` is high, the master stage is open. While `cp` is low, the slave stage copies the master and drives `q` and `q_n`.

The master's set path is enabled only while the slave holds 0, and its reset path only while the slave holds 1. Within one high phase of `cp`, the master can therefore move away from the slave value once and never move back. A brief pulse on `j` or `k` is kept, even if the input returns to its old level before `cp` falls. This is the "ones-catching" behaviour. The flip-flop does not simply follow the input levels present at the falling edge.

A status pulse `caught` marks the system cycle in which the master first departs from the slave value. An asynchronous active-low reset is released synchronously inside the block. A synchronous clear input `clr` empties both stages while the design is running.

Top module: `msjk_ff`

## Requirements
- R1: While `rst_n` is 0, `q`=0, `q_n`=1 and `caught`=0. The reset is released synchronously through a short synchronizer chain.
- R2: If `clr`=1 at a system edge, both master and slave become 0 at that edge, whatever the values of `cp`, `j` and `k`. `q` reads 0 in the cycle after.
- R3: Over one full `cp` pulse (high, then low) with steady inputs, the output follows the JK table. `j`=0, `k`=0 holds the state. `j`=0, `k`=1 gives 0. `j`=1, `k`=0 gives 1. `j`=1, `k`=1 inverts the state.
- R4: `q` does not change at any system edge where `cp` is sampled 1. At an edge where `cp` is sampled 0 and `clr`=0, the slave loads the master value, and `q` shows it in the cycle after that edge.
- R5: While the slave holds 1, `j` has no effect on the master. Only `k` can act, and it can only drive the master to 0.
- R6: While the slave holds 0, `k` has no effect on the master. Only `j` can act, and it can only drive the master to 1.
- R7: Once the master has departed from the slave value in a `cp`-high phase, later input changes in that phase cannot restore it. A one-cycle pulse on `j` (with `q`=0) or on `k` (with `q`=1) decides the next `q`.
- R8: `caught` is 1 for exactly one cycle. It is the cycle after the edge at which the master first departs from the slave value within a `cp`-high phase. It is 0 at all other times.
- R9: `q_n` is always the complement of `q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr | input | 1 | Synchronous clear of master and slave |
| cp | input | 1 | Flip-flop clock, sampled on `clk` |
| j | input | 1 | J input |
| k | input | 1 | K input |
| q | output | 1 | Slave output |
| q_n | output | 1 | Complement of `q` |
| caught | output | 1 | One-cycle pulse when the master first departs from the slave |

## Verification
Every result is due one system edge after the stimulus that causes it:

- The master and `caught` react at the edge where `cp`=1 is sampled.
- `q` reacts only at an edge where `cp`=0 is sampled.
- A clear takes effect at the edge where `clr`=1 is sampled.

The driver applies inputs at the falling edge of `clk`. It advances an independent ones-catching model through that same edge and queues the expected `q`, `q_n` and `caught`. The monitor pops one item 1 ns after each rising edge, so every comparison falls in the cycle the requirements give. Glitches on `j` and `k` last one cycle, so the held value can be told apart from the final input level.

// File: rtl/msjk_pkg.sv
package msjk_pkg;
  localparam int unsigned SYNC_STAGES_DEF = 2;

  // Gated action of the master stage for one system cycle
  typedef enum logic [1:0] {
    OP_KEEP  = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2
  } master_op_e;
endpackage

// File: rtl/msjk_rst_sync.sv
module msjk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = 1'b1;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/msjk_master.sv
module msjk_master
  import msjk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic cp,
  input  logic j,
  input  logic k,
  input  logic slave_q,
  output logic master_q,
  output logic caught
);
  master_op_e op;
  logic       master_en;
  logic       master_d;
  logic       caught_d;

  // Slave output gates the master's set and reset paths
  always_comb begin
    op = OP_KEEP;
    if (j && !slave_q) begin
      op = OP_SET;
    end else if (k && slave_q) begin
      op = OP_CLEAR;
    end
  end

  always_comb begin
    master_en = cp || clr;
    if (clr) begin
      master_d = 1'b0;
    end else begin
      case (op)
        OP_SET:   master_d = 1'b1;
        OP_CLEAR: master_d = 1'b0;
        default:  master_d = master_q;
      endcase
    end
    caught_d = !clr && cp && (op != OP_KEEP) && (master_q == slave_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_q <= 1'b0;
      caught   <= 1'b0;
    end else begin
      if (master_en) begin
        master_q <= master_d;
      end
      caught <= caught_d;
    end
  end

  AST_NO_SET_WHEN_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cp && !clr && slave_q && !master_q) |=> !master_q); // R5
  AST_NO_RESET_WHEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cp && !clr && !slave_q && master_q) |=> master_q); // R6
  AST_CLEAR_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !master_q); // R2
endmodule

// File: rtl/msjk_slave.sv
module msjk_slave (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic cp,
  input  logic master_q,
  output logic slave_q
);
  logic slave_en;
  logic slave_d;

  always_comb begin
    slave_en = clr || !cp;
    slave_d  = clr ? 1'b0 : master_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slave_q <= 1'b0;
    end else if (slave_en) begin
      slave_q <= slave_d;
    end
  end

  AST_HOLD_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (cp && !clr) |=> $stable(slave_q)); // R4
  AST_COPY_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!cp && !clr) |=> (slave_q == $past(master_q))); // R4
  AST_CLEAR_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !slave_q); // R2
endmodule

// File: rtl/msjk_ff.sv
module msjk_ff
  import msjk_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic cp,
  input  logic j,
  input  logic k,
  output logic q,
  output logic q_n,
  output logic caught
);
  logic rst_sync_n;
  logic master_q;
  logic slave_q;

  msjk_rst_sync #(.STAGES(SYNC_STAGES)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  msjk_master master_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr      (clr),
    .cp       (cp),
    .j        (j),
    .k        (k),
    .slave_q  (slave_q),
    .master_q (master_q),
    .caught   (caught)
  );

  msjk_slave slave_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr      (clr),
    .cp       (cp),
    .master_q (master_q),
    .slave_q  (slave_q)
  );

  assign q   = slave_q;
  assign q_n = ~slave_q;

  AST_CAUGHT_SINGLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    caught |=> !caught); // R8
  AST_CAUGHT_DEPARTED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    caught |-> (master_q != slave_q)); // R8
endmodule

// File: tb/msjk_ff_tb.sv
module msjk_ff_tb_top;
  logic clk = 1'b0;
  logic rst_n, clr, cp, j, k;
  logic q, q_n, caught;

  typedef struct {
    logic  exp_q;
    logic  exp_caught;
    string tag;
  } exp_t;

  exp_t exp_q_fifo[$];
  int   n_checks = 0;
  int   n_errors = 0;
  logic rm = 1'b0;
  logic rs = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  msjk_ff dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cp(cp),
    .j(j), .k(k), .q(q), .q_n(q_n), .caught(caught)
  );

  task automatic check_bit(input logic act, input logic exp, input string tag, input string what);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Driver: apply inputs, advance the reference, queue the expectation
  task automatic step(input logic c, input logic jj, input logic kk,
                      input logic cl, input string tag);
    exp_t it;
    logic ec;
    @(negedge clk);
    cp = c; j = jj; k = kk; clr = cl;
    ec = 1'b0;
    if (cl) begin
      rm = 1'b0; rs = 1'b0;
    end else if (c) begin
      if (jj && !rs) begin
        ec = (rm == rs); rm = 1'b1;
      end else if (kk && rs) begin
        ec = (rm == rs); rm = 1'b0;
      end
    end else begin
      rs = rm;
    end
    it.exp_q = rs; it.exp_caught = ec; it.tag = tag;
    exp_q_fifo.push_back(it);
  endtask

  task automatic phase(input logic jj, input logic kk, input string tag);
    step(1'b1, jj, kk, 1'b0, tag);
    step(1'b1, jj, kk, 1'b0, tag);
    step(1'b0, 1'b0, 1'b0, 1'b0, tag);
    step(1'b0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  // Monitor: compare one queued item after every rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q_fifo.size() > 0) begin
        exp_t it;
        it = exp_q_fifo.pop_front();
        check_bit(q,      it.exp_q,      it.tag, "q");
        check_bit(q_n,    ~it.exp_q,     "R9",   "q_n");
        check_bit(caught, it.exp_caught, "R8",   "caught");
      end
    end
  end

  initial begin
    #(4 * 20000);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; cp = 1'b0; j = 1'b0; k = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check_bit(q, 1'b0, "R1", "q in reset");
    check_bit(q_n, 1'b1, "R1", "q_n in reset");
    check_bit(caught, 1'b0, "R1", "caught in reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R3 truth table across full cp pulses
    phase(1'b0, 1'b0, "R3");
    phase(1'b1, 1'b0, "R3");
    phase(1'b0, 1'b0, "R3");
    phase(1'b1, 1'b1, "R3");
    phase(1'b1, 1'b1, "R3");
    phase(1'b0, 1'b1, "R3");

    // R6: q=0, K held high is ignored
    phase(1'b0, 1'b1, "R6");
    // R7: one-cycle J glitch with q=0, then K rises; master stays set
    step(1'b1, 1'b1, 1'b0, 1'b0, "R7");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b1, 1'b0, "R7");
    step(1'b0, 1'b0, 1'b0, 1'b0, "R7");
    step(1'b0, 1'b0, 1'b0, 1'b0, "R7");

    // R5: q=1, J held high is ignored
    phase(1'b1, 1'b0, "R5");
    // R7: one-cycle K glitch with q=1, then J rises; master stays reset
    step(1'b1, 1'b0, 1'b1, 1'b0, "R7");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, 1'b0, "R7");
    step(1'b0, 1'b0, 1'b0, 1'b0, "R7");
    step(1'b0, 1'b0, 1'b0, 1'b0, "R7");

    // R4: q held through a long high phase with a toggle pending
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b1, 1'b0, "R4");
    step(1'b0, 1'b0, 1'b0, 1'b0, "R4");
    step(1'b0, 1'b0, 1'b0, 1'b0, "R4");

    // R2: clear in a high phase with q=1
    step(1'b1, 1'b0, 1'b0, 1'b1, "R2");
    step(1'b1, 1'b1, 1'b1, 1'b0, "R2");
    step(1'b0, 1'b0, 1'b0, 1'b0, "R2");
    step(1'b0, 1'b0, 1'b0, 1'b0, "R2");
    // R2: clear in a low phase after the master was set
    step(1'b1, 1'b1, 1'b0, 1'b0, "R2");
    step(1'b0, 1'b0, 1'b0, 1'b1, "R2");
    step(1'b0, 1'b0, 1'b0, 1'b0, "R2");
    step(1'b0, 1'b0, 1'b0, 1'b0, "R2");

    repeat (2) @(posedge clk);
    #2;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule